// File: doc/BRIEF.md
# Packed Address-Field Execution Unit

This unit executes the integer side of a 43-bit word machine. It works on two operand words. Each word is read as a 7-bit header and three 12-bit address fields. The header holds a 6-bit opcode followed by a break bit. The unit adds or subtracts the three address fields in parallel. It also performs full-width AND, OR and XOR, one's-complement integer addition with end-around carry, and sign transfer. From the result it derives the condition flag that later conditional jumps test.

A caller presents the opcode and both operands and raises `start` for one cycle. On the next clock edge the unit registers the result, updates the condition flag and pulses `done`. Floating-point opcodes and every other code are refused. A refused code leaves the result and the flag untouched and pulses `illegal` together with `done`. Between operations every output holds its value.

Top module: `addr_field_alu`

## Requirements
- R1: Opcode 6'b000010 adds each 12-bit address field of `opb` (bits 35:24, 23:12 and 11:0) to the matching field of `opa`. Each field wraps modulo 4096, and no carry passes into the neighbouring field.
- R2: Opcode 6'b001101 subtracts each address field of `opb` from the matching field of `opa`. Each field wraps modulo 4096, and no borrow passes into the neighbouring field.
- R3: For both field operations, result bits 42:36 are copied from `opa`, whatever `opb` holds there, and the condition flag is left unchanged.
- R4: Opcodes 6'b001001, 6'b001011 and 6'b001110 give the 43-bit bitwise AND, OR and XOR of `opa` and `opb`.
- R5: After AND or OR the condition flag is 1 exactly when the result is zero. After XOR it is 1 exactly when the result is nonzero.
- R6: Opcode 6'b001111 adds `opa` and `opb` as 43-bit one's-complement integers. A carry out of bit 42 is added back into bit 0. The condition flag then takes result bit 42, which is the sign.
- R7: Opcode 6'b001000 returns `opa` with bit 42 replaced by bit 42 of `opb`, and leaves the condition flag unchanged.
- R8: Any other opcode leaves `result` and `test_flag` unchanged and raises `illegal` in the same cycle as `done`. A supported opcode keeps `illegal` at 0.
- R9: `done` is high for exactly the cycle after a cycle with `start` high. Without `start`, `result` and `test_flag` keep their values.
- R10: While `rst_n` is low, `result`, `test_flag`, `done` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the opcode and operands this cycle |
| opcode | input | 6 | Operation code |
| opa | input | 43 | First operand; header source for field operations |
| opb | input | 43 | Second operand |
| result | output | 43 | Registered result |
| test_flag | output | 1 | Registered condition flag for conditional jumps |
| done | output | 1 | One-cycle pulse, the result is valid |
| illegal | output | 1 | One-cycle pulse with `done` for a refused opcode |

## Verification
The state here is the result register, the flag register and the done/illegal pulse pair. If one of them updates at the wrong time or with the wrong value, the error is visible at the ports in the cycle after the offending `start`. A lost carry or borrow at a field boundary, or a missing end-around carry, shows as a wrong result on that same operation. An enable fault on the flag register appears later: it corrupts `test_flag` after a field add, a sign transfer or a refused opcode, because those operations must leave the flag untouched.

// File: rtl/addr_field_alu_pkg.sv
package addr_field_alu_pkg;
  localparam int FIELD_W  = 12;
  localparam int N_FIELDS = 3;
  localparam int OPC_W    = 6;
  localparam int HDR_W    = OPC_W + 1;
  localparam int WORD_W   = HDR_W + N_FIELDS * FIELD_W;
  localparam int SIGN_BIT = WORD_W - 1;

  localparam logic [OPC_W-1:0] OPC_FADD = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_FSUB = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_AND  = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_OR   = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_XOR  = 6'b001110;
  localparam logic [OPC_W-1:0] OPC_OADD = 6'b001111;
  localparam logic [OPC_W-1:0] OPC_SGN  = 6'b001000;

  typedef enum logic [1:0] {
    FLAG_KEEP,
    FLAG_ZERO,
    FLAG_NONZERO,
    FLAG_SIGN
  } flag_rule_e;

  function automatic logic [FIELD_W-1:0] lane_add(input logic [FIELD_W-1:0] x,
                                                  input logic [FIELD_W-1:0] y,
                                                  input logic sub);
    lane_add = sub ? (x - y) : (x + y);
  endfunction

  function automatic logic [WORD_W-1:0] ones_add(input logic [WORD_W-1:0] x,
                                                 input logic [WORD_W-1:0] y);
    logic [WORD_W:0] raw;
    raw = {1'b0, x} + {1'b0, y};
    ones_add = raw[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw[WORD_W]};
  endfunction
endpackage

// File: rtl/field_lane_alu.sv
module field_lane_alu
  import addr_field_alu_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NF = N_FIELDS,
  localparam int TOT_W = FW * NF
) (
  input  logic             sub,
  input  logic [TOT_W-1:0] fa,
  input  logic [TOT_W-1:0] fb,
  output logic [TOT_W-1:0] fy
);
  for (genvar g = 0; g < NF; g++) begin : g_lane
    assign fy[g*FW +: FW] = lane_add(fa[g*FW +: FW], fb[g*FW +: FW], sub);
  end
endmodule

// File: rtl/word_logic_alu.sv
module word_logic_alu
  import addr_field_alu_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [OPC_W-1:0] op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     y,
  output flag_rule_e       rule,
  output logic             hit
);
  always_comb begin
    y    = a;
    rule = FLAG_KEEP;
    hit  = 1'b1;
    case (op)
      OPC_AND:  begin y = a & b; rule = FLAG_ZERO;    end
      OPC_OR:   begin y = a | b; rule = FLAG_ZERO;    end
      OPC_XOR:  begin y = a ^ b; rule = FLAG_NONZERO; end
      OPC_OADD: begin y = ones_add(a, b); rule = FLAG_SIGN; end
      OPC_SGN:  begin y = {b[W-1], a[W-2:0]}; end
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/addr_field_alu.sv
module addr_field_alu
  import addr_field_alu_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NF = N_FIELDS,
  localparam int HW = HDR_W,
  localparam int W  = HW + FW * NF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  output logic [W-1:0]     result,
  output logic             test_flag,
  output logic             done,
  output logic             illegal
);
  localparam int FT = FW * NF;

  // named internal events for checking
  logic             is_field_op;
  logic             is_sub;
  logic [FT-1:0]    field_y;
  logic [W-1:0]     logic_y;
  flag_rule_e       logic_rule;
  logic             logic_hit;
  logic             supported;
  logic [W-1:0]     next_y;
  logic             flag_load;
  logic             flag_val;

  assign is_sub      = (opcode == OPC_FSUB);
  assign is_field_op = (opcode == OPC_FADD) || is_sub;

  field_lane_alu #(.FW(FW), .NF(NF)) u_fields (
    .sub (is_sub),
    .fa  (opa[FT-1:0]),
    .fb  (opb[FT-1:0]),
    .fy  (field_y)
  );

  word_logic_alu #(.W(W)) u_logic (
    .op   (opcode),
    .a    (opa),
    .b    (opb),
    .y    (logic_y),
    .rule (logic_rule),
    .hit  (logic_hit)
  );

  assign supported = is_field_op || logic_hit;
  assign next_y    = is_field_op ? {opa[W-1:FT], field_y} : logic_y;

  always_comb begin
    flag_load = 1'b1;
    flag_val  = 1'b0;
    case (logic_rule)
      FLAG_ZERO:    flag_val = (logic_y == '0);
      FLAG_NONZERO: flag_val = (logic_y != '0);
      FLAG_SIGN:    flag_val = logic_y[W-1];
      default:      flag_load = 1'b0;
    endcase
    if (is_field_op || !logic_hit) flag_load = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      test_flag <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done    <= start;
      illegal <= start && !supported;
      if (start && supported) result <= next_y;
      if (start && flag_load) test_flag <= flag_val;
    end
  end

  // R9: done follows start by one cycle
  a_r9_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R9: no start, no done
  a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R8: illegal only together with done
  a_r8_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);
  // R8: refused opcode leaves state
  a_r8_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !supported) |=> ($stable(result) && $stable(test_flag)));
  // R3: header copied from opa on field ops
  a_r3_header_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_field_op) |=> (result[W-1:FT] == $past(opa[W-1:FT])));
  // R3: field ops leave the flag
  a_r3_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_field_op) |=> $stable(test_flag));
  // R5: zero rule after AND
  a_r5_and_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opcode == OPC_AND) |=> (test_flag == (result == '0)));
  // R6: flag tracks sign after one's-complement add
  a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opcode == OPC_OADD) |=> (test_flag == result[W-1]));
  // R9: outputs hold without start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(test_flag)));
endmodule

// File: tb/addr_field_alu_tb.sv
module addr_field_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  opcode = '0;
  logic [42:0] opa = '0;
  logic [42:0] opb = '0;
  logic [42:0] result;
  logic        test_flag;
  logic        done;
  logic        illegal;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  addr_field_alu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .opa(opa), .opb(opb), .result(result), .test_flag(test_flag),
    .done(done), .illegal(illegal)
  );

  localparam int NV = 11;
  // flag code: 0/1 expected value, 2 = unchanged
  localparam logic [5:0]  V_OP [NV] = '{6'b000010, 6'b001101, 6'b001001, 6'b001011,
    6'b001011, 6'b001110, 6'b001110, 6'b001111, 6'b001111, 6'b001000, 6'b001001};
  localparam logic [42:0] V_A [NV] = '{
    {6'h02, 1'b1, 12'd4095, 12'd10, 12'd0},
    {6'h0D, 1'b0, 12'd0, 12'd100, 12'd5},
    43'h000000000FF, 43'h0, 43'h40000000001, 43'h123456789AB, 43'h123456789AB,
    43'h7FFFFFFFFFF, 43'h40000000000, 43'h00000000ABC, 43'h7FFFFFFFFFF};
  localparam logic [42:0] V_B [NV] = '{
    {6'h3F, 1'b0, 12'd1, 12'd20, 12'd4095},
    {6'h00, 1'b1, 12'd1, 12'd40, 12'd5},
    43'h00000000F00, 43'h0, 43'h00000000010, 43'h123456789AB, 43'h123456789AA,
    43'h00000000001, 43'h00000000005, 43'h40000000000, 43'h00000005555};
  localparam logic [42:0] V_Y [NV] = '{
    {6'h02, 1'b1, 12'd0, 12'd30, 12'd4095},
    {6'h0D, 1'b0, 12'd4095, 12'd60, 12'd0},
    43'h0, 43'h0, 43'h40000000011, 43'h0, 43'h00000000001,
    43'h00000000001, 43'h40000000005, 43'h40000000ABC, 43'h00000005555};
  localparam logic [1:0] V_F [NV] = '{2, 2, 1, 1, 0, 0, 1, 0, 1, 2, 0};
  localparam string V_REQ [NV] = '{"R1/R3", "R2/R3", "R4/R5", "R4/R5", "R4/R5",
    "R4/R5", "R4/R5", "R6", "R6", "R7", "R4/R5"};

  logic exp_flag = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [42:0] act, input logic [42:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [42:0] a, input logic [42:0] b);
    @(negedge clk);
    start = 1'b1; opcode = op; opa = a; opb = b;
    @(posedge clk);
    #1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10", "result", result, 43'h0);
    check("R10", "flag", {42'h0, test_flag}, 43'h0);
    check("R10", "done", {42'h0, done}, 43'h0);
    check("R10", "illegal", {42'h0, illegal}, 43'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], V_A[i], V_B[i]);
      // sampled at the negedge after the registering edge
      if (V_F[i] != 2) exp_flag = V_F[i][0];
      check(V_REQ[i], "result", result, V_Y[i]);
      check(V_REQ[i], "flag", {42'h0, test_flag}, {42'h0, exp_flag});
      check("R9", "done", {42'h0, done}, 43'h1);
      check("R8", "illegal on supported", {42'h0, illegal}, 43'h0);
    end

    // R9: idle cycle, done drops and outputs hold
    @(posedge clk); #1;
    check("R9", "done idle", {42'h0, done}, 43'h0);
    check("R9", "result hold", result, V_Y[NV-1]);
    check("R9", "flag hold", {42'h0, test_flag}, {42'h0, exp_flag});

    // R8: refused opcodes (floating add, multiply)
    issue(6'b000001, 43'h7FFFFFFFFFF, 43'h7FFFFFFFFFF);
    check("R8", "result kept", result, V_Y[NV-1]);
    check("R8", "flag kept", {42'h0, test_flag}, {42'h0, exp_flag});
    check("R8", "illegal", {42'h0, illegal}, 43'h1);
    check("R8", "done", {42'h0, done}, 43'h1);
    issue(6'b000101, 43'h0, 43'h0);
    check("R8", "illegal mul", {42'h0, illegal}, 43'h1);
    check("R8", "result kept mul", result, V_Y[NV-1]);

    // R6: negative-zero sum plus end-around carry
    issue(6'b001111, 43'h7FFFFFFFFFE, 43'h7FFFFFFFFFF);
    check("R6", "double carry", result, 43'h7FFFFFFFFFE);
    check("R6", "flag sign", {42'h0, test_flag}, 43'h1);

    // R7: sign cleared, flag stays 1
    issue(6'b001000, 43'h7FFFFFFFFFF, 43'h00000000000);
    check("R7", "sign cleared", result, 43'h3FFFFFFFFFF);
    check("R7", "flag unchanged", {42'h0, test_flag}, 43'h1);

    // R10: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R10", "result after reset", result, 43'h0);
    check("R10", "flag after reset", {42'h0, test_flag}, 43'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule